// File: doc/BRIEF.md
# Serial-Controlled Successive-Approximation Converter Sequencer

This block is the digital core of an 8-bit successive-approximation converter that a host controls over a three-wire serial link. While chip select is low, the host clocks a start-framed assignment word into the block on the data input. The word picks the analog channel and how its negative input is formed. The block then drives trial codes to an external resistor ladder and reads back an external comparator, one decision per clock. It streams each result bit out as soon as that bit is decided, most significant bit first. It then replays the same result least significant bit first.

The block is built in two configurations, chosen by a parameter. The 4-channel configuration uses a 3-bit assignment word and replays the result automatically. The 8-channel configuration uses a 4-bit word and references single-ended channels to a common terminal. In that configuration the replay is held on the least significant bit until the host drives the serial-order select low. The data output has a separate output-enable. Because of this, the data input and the data output can share one host wire. The data input is read only before the output is enabled.

All pins are plain control and data pins. The host has no ready signal and cannot hold the result stream back, except for the order select in the 8-channel configuration.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_n` is high, every register is cleared at once (asynchronously): `dout_oe`=0, `dout`=0, `busy`=0, `trial_code`=0, `mux_valid`=0.
- R2: The block samples `din` on rising `sclk` edges. Leading zeros are ignored, and the first 1 is the start bit. The assignment word is latched on the rising edge at which the start bit has moved through all assignment bits, which is edge start+3 (4-channel) or start+4 (8-channel). On that edge `mux_valid` and `busy` go high.
- R3: The assignment word follows the start bit in this order: single-ended flag (1 = single-ended), odd flag, then the select bits, most significant first. `pos_ch` = {select, odd}. In differential mode `neg_src`=1 (paired channel) and `neg_ch` = `pos_ch` with bit 0 inverted. In single-ended mode `neg_src`=0 (ground) in the 4-channel configuration and `neg_src`=2 (common terminal) in the 8-channel configuration. The selection holds until `cs_n` rises.
- R4: Before the latch edge `dout_oe` is 0. On the falling edge right after the latch edge, `dout_oe` goes to 1 and `dout` drives 0 for one clock. This is the settling slot.
- R5: The trial code 0x80 is presented from the latch edge. Each following rising edge samples `cmp_hi` (1 = positive input at or above the ladder). The current trial bit is kept if `cmp_hi` is 1 and cleared if it is 0, and the next lower bit is set. The final code is the binary-search result.
- R6: After the settling slot, the falling edges that follow the 8 decision edges put result bits 7 down to 0 on `dout`. `busy` is high for exactly 8 clocks and falls on the eighth decision edge.
- R7: A positive input below the negative input gives a result of 0x00.
- R8: In the 4-channel configuration, result bit 0 stays on `dout` for one clock. On the following falling edges the block then outputs bits 1 to 7, and after that a low.
- R9: In the 8-channel configuration, bit 0 stays on `dout` for as long as `order_sel` is sampled high after the conversion. Each rising edge with `order_sel` low moves the replay on by one bit.
- R10: After the replay, `dout` stays low and `trial_code`, `busy` and the selection do not change. `din` has no effect after the latch edge. A new conversion needs `cs_n` to rise and fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low; high clears the block |
| din | input | 1 | Serial assignment data, sampled on rising edges |
| cmp_hi | input | 1 | External comparator: positive input at or above ladder |
| order_sel | input | 1 | Serial-order select; low lets the LSB-first replay advance (8-channel only) |
| dout | output | 1 | Serial result data, changes on falling edges |
| dout_oe | output | 1 | Output-enable for the tristate driver of dout |
| busy | output | 1 | Conversion in progress |
| trial_code | output | 8 | Code driven to the external ladder |
| pos_ch | output | log2(NUM_CH) | Channel routed to the positive comparator input |
| neg_ch | output | log2(NUM_CH) | Paired channel used as negative input in differential mode |
| neg_src | output | 2 | Negative input source: 0 ground, 1 paired channel, 2 common terminal |
| mux_valid | output | 1 | Channel selection latched |

## Verification
All timing is counted from the latch edge L. `busy` and the selection are due 0 cycles after the rising edge that causes them, so the bench reads them 3 ns after each rising edge. `dout` and `dout_oe` are due half a clock later, so the bench reads them 3 ns after the falling edge that follows rising edge L+k: the settling low at k=0, result bit 7-(k-1) for k=1 to 8, then the replayed bits, shifted later by the number of edges at which the order select was held high. The bench records both kinds of sample for every edge of a transaction. It then compares them with a schedule worked out from these offsets, so a bit that shows up one clock early or late is reported.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    NEG_GND  = 2'd0,
    NEG_PAIR = 2'd1,
    NEG_COM  = 2'd2
  } neg_src_e;

  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_CONV   = 2'd1,
    PH_REPLAY = 2'd2,
    PH_DONE   = 2'd3
  } phase_e;

endpackage

// File: rtl/sar_addr_shift.sv
module sar_addr_shift #(
  parameter int ADDR_W = 4
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              shift_en,
  input  logic              din,
  output logic              start_hit,
  output logic [ADDR_W-1:0] word
);

  logic [ADDR_W:0] sr_q;
  logic [ADDR_W:0] sr_nxt;

  assign sr_nxt    = {sr_q[ADDR_W-1:0], din};
  assign start_hit = shift_en && sr_nxt[ADDR_W];
  assign word      = sr_nxt[ADDR_W-1:0];

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n)          sr_q <= '0;
    else if (shift_en) sr_q <= sr_nxt;
  end

  // R10: once the address is taken, din can no longer reach the register
  a_r10_din_ignored: assert property (@(posedge sclk) disable iff (cs_n)
    !shift_en |=> $stable(sr_q));

endmodule

// File: rtl/sar_mux_decode.sv
module sar_mux_decode import sar_seq_pkg::*; #(
  parameter int NUM_CH = 8
) (
  input  logic                      sclk,
  input  logic                      cs_n,
  input  logic                      load,
  input  logic [$clog2(NUM_CH):0]   word,
  output logic [$clog2(NUM_CH)-1:0] pos_ch,
  output logic [$clog2(NUM_CH)-1:0] neg_ch,
  output logic [1:0]                neg_src,
  output logic                      mux_valid
);

  localparam int CH_W   = $clog2(NUM_CH);
  localparam int SEL_W  = CH_W - 1;
  localparam int ADDR_W = CH_W + 1;

  logic            w_single;
  logic            w_odd;
  logic [SEL_W-1:0] w_sel;
  neg_src_e        se_ref;
  neg_src_e        src_d;
  logic [CH_W-1:0] pos_d;
  logic [CH_W-1:0] neg_d;

  assign w_single = word[ADDR_W-1];
  assign w_odd    = word[ADDR_W-2];
  assign w_sel    = word[SEL_W-1:0];

  generate
    if (NUM_CH >= 8) begin : g_common_ref
      assign se_ref = NEG_COM;
    end else begin : g_ground_ref
      assign se_ref = NEG_GND;
    end
  endgenerate

  always_comb begin
    pos_d = {w_sel, w_odd};
    neg_d = {w_sel, ~w_odd};
    src_d = w_single ? se_ref : NEG_PAIR;
  end

  logic [CH_W-1:0] pos_q, neg_q;
  logic [1:0]      src_q;
  logic            val_q;

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      pos_q <= '0;
      neg_q <= '0;
      src_q <= NEG_GND;
      val_q <= 1'b0;
    end else if (load && !val_q) begin
      pos_q <= pos_d;
      neg_q <= neg_d;
      src_q <= src_d;
      val_q <= 1'b1;
    end
  end

  assign pos_ch    = pos_q;
  assign neg_ch    = neg_q;
  assign neg_src   = src_q;
  assign mux_valid = val_q;

  // R3: selection stays put for the rest of the transaction
  a_r3_select_held: assert property (@(posedge sclk) disable iff (cs_n)
    val_q |=> (val_q && $stable(pos_q) && $stable(src_q)));

  // R3: a differential partner is always the other member of the same pair
  a_r3_pair_adjacent: assert property (@(posedge sclk) disable iff (cs_n)
    (val_q && src_q == NEG_PAIR) |->
      ((neg_q >> 1) == (pos_q >> 1) && neg_q[0] != pos_q[0]));

endmodule

// File: rtl/sar_search.sv
module sar_search import sar_seq_pkg::*; #(
  parameter int RES_W       = 8,
  parameter bit ORDER_GATED = 1'b1
) (
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             start_hit,
  input  logic             cmp_hi,
  input  logic             order_sel,
  output logic             addr_en,
  output logic             busy,
  output logic [RES_W-1:0] trial,
  output logic             line_en,
  output logic             line_bit
);

  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  phase_e           ph_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] trial_q;
  logic [RES_W:0]   rep_q;
  logic [IDX_W-1:0] rcnt_q;
  logic             busy_q, en_q, bit_q;

  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] trial_nxt;
  logic             advance;

  assign advance = !(ORDER_GATED && order_sel);

  always_comb begin
    decided        = trial_q;
    decided[idx_q] = cmp_hi;
    trial_nxt      = decided;
    if (idx_q != '0) trial_nxt[idx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      ph_q    <= PH_ADDR;
      idx_q   <= '0;
      trial_q <= '0;
      rep_q   <= '0;
      rcnt_q  <= '0;
      busy_q  <= 1'b0;
      en_q    <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_ADDR: begin
          if (start_hit) begin
            ph_q    <= PH_CONV;
            idx_q   <= TOP_IDX;
            trial_q <= {1'b1, {(RES_W-1){1'b0}}};
            busy_q  <= 1'b1;
            en_q    <= 1'b1;
            bit_q   <= 1'b0;
          end
        end
        PH_CONV: begin
          bit_q <= cmp_hi;
          if (idx_q == '0) begin
            trial_q <= decided;
            rep_q   <= {1'b0, decided};
            rcnt_q  <= '0;
            busy_q  <= 1'b0;
            ph_q    <= PH_REPLAY;
          end else begin
            trial_q <= trial_nxt;
            idx_q   <= idx_q - 1'b1;
          end
        end
        PH_REPLAY: begin
          if (advance) begin
            rep_q  <= rep_q >> 1;
            bit_q  <= rep_q[1];
            rcnt_q <= rcnt_q + 1'b1;
            if (rcnt_q == TOP_IDX) ph_q <= PH_DONE;
          end
        end
        default: begin
          ph_q <= PH_DONE;
        end
      endcase
    end
  end

  assign addr_en  = (ph_q == PH_ADDR);
  assign busy     = busy_q;
  assign trial    = trial_q;
  assign line_en  = en_q;
  assign line_bit = bit_q;

  // R2: busy can only rise out of the address phase
  a_r2_busy_from_addr: assert property (@(posedge sclk) disable iff (cs_n)
    $rose(busy_q) |-> ($past(ph_q) == PH_ADDR));

  // R6: the last decision edge ends busy
  a_r6_busy_ends: assert property (@(posedge sclk) disable iff (cs_n)
    (ph_q == PH_CONV && idx_q == '0) |=> !busy_q);

  // R5: a decided bit equals the comparator value seen at its decision edge
  a_r5_bit_kept: assert property (@(posedge sclk) disable iff (cs_n)
    (ph_q == PH_CONV) |=> (trial_q[$past(idx_q)] == $past(cmp_hi)));

  // R9: a held order select freezes the replayed bit
  a_r9_hold_lsb: assert property (@(posedge sclk) disable iff (cs_n)
    (ph_q == PH_REPLAY && !advance) |=> $stable(bit_q));

  // R10: after the replay nothing moves and the line stays low
  a_r10_quiet_end: assert property (@(posedge sclk) disable iff (cs_n)
    (ph_q == PH_DONE) |=> (ph_q == PH_DONE && $stable(trial_q) && !bit_q && !busy_q));

endmodule

// File: rtl/sar_dout_retime.sv
module sar_dout_retime (
  input  logic sclk,
  input  logic cs_n,
  input  logic line_en,
  input  logic line_bit,
  output logic dout,
  output logic dout_oe
);

  logic oe_q, d_q;

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      oe_q <= 1'b0;
      d_q  <= 1'b0;
    end else begin
      oe_q <= line_en;
      d_q  <= line_bit;
    end
  end

  assign dout    = d_q;
  assign dout_oe = oe_q;

  // R4: the first driven clock of the output is the settling low
  a_r4_lead_low: assert property (@(posedge sclk) disable iff (cs_n)
    $rose(oe_q) |-> !d_q);

  // R1: the output is never driven without the enable
  a_r1_quiet_off: assert property (@(posedge sclk) disable iff (cs_n)
    !oe_q |-> !d_q);

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq import sar_seq_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 8
) (
  input  logic                      sclk,
  input  logic                      cs_n,
  input  logic                      din,
  input  logic                      cmp_hi,
  input  logic                      order_sel,
  output logic                      dout,
  output logic                      dout_oe,
  output logic                      busy,
  output logic [RES_W-1:0]          trial_code,
  output logic [$clog2(NUM_CH)-1:0] pos_ch,
  output logic [$clog2(NUM_CH)-1:0] neg_ch,
  output logic [1:0]                neg_src,
  output logic                      mux_valid
);

  localparam int CH_W        = $clog2(NUM_CH);
  localparam int ADDR_W      = CH_W + 1;
  localparam bit ORDER_GATED = (NUM_CH >= 8);

  logic              addr_en;
  logic              start_hit;
  logic [ADDR_W-1:0] word;
  logic              line_en, line_bit;

  sar_addr_shift #(.ADDR_W(ADDR_W)) u_addr (
    .sclk      (sclk),
    .cs_n      (cs_n),
    .shift_en  (addr_en),
    .din       (din),
    .start_hit (start_hit),
    .word      (word)
  );

  sar_mux_decode #(.NUM_CH(NUM_CH)) u_mux (
    .sclk      (sclk),
    .cs_n      (cs_n),
    .load      (start_hit),
    .word      (word),
    .pos_ch    (pos_ch),
    .neg_ch    (neg_ch),
    .neg_src   (neg_src),
    .mux_valid (mux_valid)
  );

  sar_search #(.RES_W(RES_W), .ORDER_GATED(ORDER_GATED)) u_search (
    .sclk      (sclk),
    .cs_n      (cs_n),
    .start_hit (start_hit),
    .cmp_hi    (cmp_hi),
    .order_sel (order_sel),
    .addr_en   (addr_en),
    .busy      (busy),
    .trial     (trial_code),
    .line_en   (line_en),
    .line_bit  (line_bit)
  );

  sar_dout_retime u_out (
    .sclk     (sclk),
    .cs_n     (cs_n),
    .line_en  (line_en),
    .line_bit (line_bit),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  // R2: selection and busy appear together on the latch edge
  a_r2_latch_with_busy: assert property (@(posedge sclk) disable iff (cs_n)
    $rose(busy) |-> (mux_valid && $rose(mux_valid)));

endmodule

// File: tb/sar_serial_seq_bench.sv
module sar_serial_seq_bench;

  localparam int NE = 34;

  logic sclk = 1'b0;
  always #10 sclk = ~sclk;

  logic cs8_n = 1'b1, din8 = 1'b0, cs4_n = 1'b1, din4 = 1'b0, order_sel = 1'b1;
  logic cmp8, cmp4;

  logic       dout8, oe8, busy8, val8;
  logic [7:0] trial8;
  logic [2:0] pos8, nch8;
  logic [1:0] nsrc8;

  logic       dout4, oe4, busy4, val4;
  logic [7:0] trial4;
  logic [1:0] pos4, nch4;
  logic [1:0] nsrc4;

  int ana [0:7];
  int com_v = 0;

  function automatic logic ladder(input int pv, input int nv, input int t);
    return ((pv - nv) >= t);
  endfunction

  assign cmp8 = ladder(ana[pos8], (nsrc8 == 2'd0) ? 0 : (nsrc8 == 2'd1) ? ana[nch8] : com_v, int'(trial8));
  assign cmp4 = ladder(ana[pos4], (nsrc4 == 2'd0) ? 0 : (nsrc4 == 2'd1) ? ana[nch4] : com_v, int'(trial4));

  sar_serial_seq #(.NUM_CH(8), .RES_W(8)) u_sar_serial_seq (
    .sclk(sclk), .cs_n(cs8_n), .din(din8), .cmp_hi(cmp8), .order_sel(order_sel),
    .dout(dout8), .dout_oe(oe8), .busy(busy8), .trial_code(trial8),
    .pos_ch(pos8), .neg_ch(nch8), .neg_src(nsrc8), .mux_valid(val8)
  );

  sar_serial_seq #(.NUM_CH(4), .RES_W(8)) u_sar_serial_seq_q (
    .sclk(sclk), .cs_n(cs4_n), .din(din4), .cmp_hi(cmp4), .order_sel(order_sel),
    .dout(dout4), .dout_oe(oe4), .busy(busy4), .trial_code(trial4),
    .pos_ch(pos4), .neg_ch(nch4), .neg_src(nsrc4), .mux_valid(val4)
  );

  int total = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // fields: cfg8, lead, single, odd, sel[1:0], hold[2:0], vpos, vneg
  localparam logic [25:0] VEC [0:8] = '{
    {1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 3'd0, 8'hA5, 8'd0},
    {1'b0, 2'd2, 1'b1, 1'b1, 2'd1, 3'd0, 8'h3C, 8'd0},
    {1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 3'd0, 8'd200, 8'd55},
    {1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 3'd0, 8'd10, 8'd90},
    {1'b1, 2'd0, 1'b1, 1'b1, 2'd3, 3'd0, 8'd255, 8'd0},
    {1'b1, 2'd3, 1'b1, 1'b0, 2'd2, 3'd5, 8'd180, 8'd60},
    {1'b1, 2'd1, 1'b0, 1'b1, 2'd1, 3'd2, 8'd77, 8'd76},
    {1'b1, 2'd0, 1'b0, 1'b0, 2'd3, 3'd7, 8'd0, 8'd0},
    {1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 3'd1, 8'd50, 8'd200}
  };

  task automatic run_vec(input logic [25:0] v);
    bit c8, sgl, odd;
    logic [1:0] sel;
    int lead, hold, vp, vn, aw, e0, epos, eneg, esrc, negv, expr, rep0;
    logic strm [0:NE];
    int bsy [0:NE-1];
    int oe  [0:NE-1];
    int dq  [0:NE-1];
    int msb, lsb, bcount, tailbad, holdbad, p;
    c8 = v[25]; lead = int'(v[24:23]); sgl = v[22]; odd = v[21]; sel = v[20:19];
    hold = c8 ? int'(v[18:16]) : 0; vp = int'(v[15:8]); vn = int'(v[7:0]);
    aw = c8 ? 4 : 3;
    e0 = lead + aw;
    epos = c8 ? int'({sel, odd}) : int'({sel[0], odd});
    eneg = epos ^ 1;
    esrc = sgl ? (c8 ? 2 : 0) : 1;
    for (int k = 0; k < 8; k++) ana[k] = (k * 37 + 11) & 255;
    ana[epos] = vp;
    if (!sgl) ana[eneg] = vn;
    com_v = vn;
    negv = (esrc == 0) ? 0 : vn;
    expr = (vp - negv < 0) ? 0 : vp - negv;
    for (int i = 0; i <= NE; i++) strm[i] = (i % 3 == 0);
    for (int i = 0; i < lead; i++) strm[i] = 1'b0;
    strm[lead] = 1'b1; strm[lead+1] = sgl; strm[lead+2] = odd;
    if (c8) begin strm[lead+3] = sel[1]; strm[lead+4] = sel[0]; end
    else strm[lead+3] = sel[0];
    rep0 = e0 + 9 + hold;
    @(negedge sclk); #3;
    if (c8) begin cs8_n = 1'b0; din8 = strm[0]; end
    else    begin cs4_n = 1'b0; din4 = strm[0]; end
    order_sel = 1'b1;
    for (int i = 0; i < NE; i++) begin
      @(posedge sclk); #3;
      bsy[i] = c8 ? int'(busy8) : int'(busy4);
      @(negedge sclk); #3;
      oe[i] = c8 ? int'(oe8) : int'(oe4);
      dq[i] = c8 ? int'(dout8) : int'(dout4);
      if (c8) din8 = strm[i+1]; else din4 = strm[i+1];
      order_sel = ((i + 1) < rep0);
    end
    // R2: start detection and latch timing
    chk(bsy[e0-1] == 0 && bsy[e0] == 1, "R2", "busy rise at latch edge", bsy[e0-1]*2 + bsy[e0], 1);
    // R3: decoded selection
    chk((c8 ? int'(pos8) : int'(pos4)) == epos, "R3", "pos_ch", c8 ? int'(pos8) : int'(pos4), epos);
    chk((c8 ? int'(nsrc8) : int'(nsrc4)) == esrc, "R3", "neg_src", c8 ? int'(nsrc8) : int'(nsrc4), esrc);
    if (!sgl) chk((c8 ? int'(nch8) : int'(nch4)) == eneg, "R3", "neg_ch", c8 ? int'(nch8) : int'(nch4), eneg);
    // R4: settling low
    chk(oe[e0-1] == 0 && oe[e0] == 1 && dq[e0] == 0, "R4", "settling slot oe/dout",
        oe[e0-1]*4 + oe[e0]*2 + dq[e0], 2);
    // R6: busy lasts eight clocks
    bcount = 0;
    for (int i = 0; i < NE; i++) bcount += bsy[i];
    chk(bcount == 8 && bsy[e0+8] == 0, "R6", "busy clocks", bcount, 8);
    // R5 / R7: MSB-first result
    msb = 0;
    for (int k = 1; k <= 8; k++) msb = (msb << 1) | dq[e0+k];
    if (vp < negv) chk(msb == 0, "R7", "negative input result", msb, 0);
    else           chk(msb == expr, "R5", "MSB-first result", msb, expr);
    // R8 / R9: LSB-first replay
    holdbad = 0;
    for (int i = e0 + 8; i <= e0 + 8 + hold; i++) if (dq[i] != (expr & 1)) holdbad++;
    lsb = dq[e0+8];
    for (int k = 1; k <= 7; k++) begin
      p = e0 + 8 + hold + k;
      lsb = lsb | (dq[p] << k);
    end
    if (c8) begin
      chk(holdbad == 0, "R9", "LSB held while order select high", holdbad, 0);
      chk(lsb == expr, "R9", "gated LSB-first replay", lsb, expr);
    end else begin
      chk(lsb == expr, "R8", "automatic LSB-first replay", lsb, expr);
    end
    // R10: quiet tail, din ignored, no restart without a new chip-select edge
    tailbad = 0;
    for (int i = e0 + 16 + hold; i < NE; i++) if (dq[i] != 0 || bsy[i] != 0 || oe[i] != 1) tailbad++;
    chk(tailbad == 0, "R10", "quiet after replay", tailbad, 0);
    chk((c8 ? int'(trial8) : int'(trial4)) == expr, "R10", "trial code held",
        c8 ? int'(trial8) : int'(trial4), expr);
    @(negedge sclk); #3;
    if (c8) begin cs8_n = 1'b1; din8 = 1'b0; end
    else    begin cs4_n = 1'b1; din4 = 1'b0; end
    order_sel = 1'b1;
    @(negedge sclk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) ana[k] = 0;
    repeat (3) @(negedge sclk);
    #3;
    // R1: reset state with chip select high
    chk(!oe8 && !busy8 && trial8 == 0 && !val8 && !dout8, "R1", "cleared state 8ch",
        int'({oe8, busy8, val8, dout8}) + int'(trial8), 0);
    chk(!oe4 && !busy4 && trial4 == 0 && !val4 && !dout4, "R1", "cleared state 4ch",
        int'({oe4, busy4, val4, dout4}) + int'(trial4), 0);

    for (int n = 0; n < 9; n++) run_vec(VEC[n]);

    // R1: abort in the middle of a conversion
    ana[1] = 140;
    @(negedge sclk); #3;
    cs8_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      din8 = (i == 0 || i == 1 || i == 2);
      @(negedge sclk); #3;
    end
    chk(busy8 && oe8 && val8, "R1", "conversion running before abort", int'({busy8, oe8, val8}), 7);
    cs8_n = 1'b1;
    #2;
    chk(!busy8 && !oe8 && !val8 && trial8 == 0 && !dout8, "R1", "cleared at chip-select rise",
        int'({busy8, oe8, val8, dout8}) + int'(trial8), 0);
    din8 = 1'b0;
    @(negedge sclk);

    // R10: a fresh chip-select edge gives a complete new conversion
    run_vec({1'b1, 2'd2, 1'b1, 1'b1, 2'd0, 3'd3, 8'd99, 8'd33});

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule